// File: doc/BRIEF.md
# Byte-Register SPI Command Engine

This block is an SPI master that runs one serial-flash command each time software triggers it. Software programs, through a byte-wide register port, an opcode, a packed pair of byte counts and up to eight payload bytes. The payload bytes go into an eight-entry ring buffer, which software reaches through a single data port with an auto-advancing pointer. Setting the go bit pulls chip select low. The engine then clocks out the opcode, then the payload bytes, then one 0xFF filler byte for each requested response byte. The go bit stays set until chip select has returned high.

The ring buffer is shared by both directions. Every byte period after the opcode writes the byte sampled from the serial input back into the current entry and moves the pointer on, so the entries that held the payload end up holding the bytes echoed while it was sent. To collect a reply, software resets the pointer, reads and discards as many bytes as it sent, and then reads the response bytes. The buffer is never wiped, so entries that no command touches keep their old contents.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select is high, SCK is low, the go bit reads 0 and the pointer reads 0.
- R2: Offset 0x1 holds the receive count in bits 7:4 and the transmit count in bits 3:0. On write, a field above 8 is stored as 8. The stored value reads back.
- R3: When idle, a read or a write at offset 0xC accesses the entry at the pointer, then advances the pointer by one modulo 8. The pointer reads back in bits 2:0 of offset 0xD.
- R4: When idle, writing offset 0x2 with bit 4 set returns the pointer to 0.
- R5: When idle, writing offset 0x2 with bit 0 set starts a command and also returns the pointer to 0. Bit 0 of offset 0x2 reads 1 until the command ends and 0 afterwards.
- R6: The opcode at offset 0x0 is the first byte sent, MSB first, in SPI mode 0. SCK idles low while chip select is high. MOSI changes only while SCK is low.
- R7: After the opcode, the engine sends the transmit-count bytes from buffer entries 0, 1, … in order, then sends 0xFF once for each receive byte.
- R8: Every byte period after the opcode stores its received byte at the current entry and advances the pointer. After a command the pointer is (tx+rx) mod 8, and entries that were not touched keep their contents.
- R9: A command gives exactly 8·(1+tx+rx) SCK rising edges, including an opcode-only command with a nonzero receive count. No response byte is lost.
- R10: Chip select rises one half SCK period (DIV_HALF clock cycles) after the last SCK falling edge. The go bit clears in the same cycle.
- R11: While a command runs, writes to offsets 0x0, 0x1, 0x2 and 0xC have no effect, and reads at 0xC do not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; side effect at offset 0xC |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
Two activities can fall on the same cycle. A register access can arrive while the engine is shifting, and both then try to use the single pointer and the single buffer write port. A control write can also carry the pointer-reset bit and the go bit together. The bench starts a command with both control bits set. While that command runs, it writes the opcode, count, control and data registers and reads the data port. It then judges the outcome from the final pointer value, the unchanged opcode and count registers, and a read-back of all eight entries against an arithmetic model of the ring.

// File: rtl/spi_cmd_pkg.sv
`timescale 1ns/1ps
package spi_cmd_pkg;
   localparam logic [3:0] OFS_OPCODE = 4'h0;
   localparam logic [3:0] OFS_COUNT  = 4'h1;
   localparam logic [3:0] OFS_CTRL   = 4'h2;
   localparam logic [3:0] OFS_DATA   = 4'hC;
   localparam logic [3:0] OFS_PTR    = 4'hD;
   localparam int CTRL_GO_BIT   = 0;
   localparam int CTRL_PCLR_BIT = 4;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_LOAD  = 2'd1,
      SQ_SHIFT = 2'd2,
      SQ_TAIL  = 2'd3
   } seq_state_t;
endpackage

// File: rtl/spi_half_tick.sv
`timescale 1ns/1ps
module spi_half_tick #(
   parameter int DIV_HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!run)          cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end

   assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/spi_byte_shift.sv
`timescale 1ns/1ps
module spi_byte_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   input  logic         tick,
   input  logic         miso_i,
   output logic         sck_o,
   output logic         mosi_o,
   output logic         done,
   output logic [W-1:0] rx_byte
);
   localparam int HCW = $clog2(2 * W);
   localparam logic [HCW-1:0] LAST = HCW'(2 * W - 1);

   logic           active_q;
   logic [HCW-1:0] hcnt_q;
   logic [W-1:0]   tx_sr_q;
   logic [W-1:0]   rx_sr_q;
   logic           sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         hcnt_q   <= '0;
         tx_sr_q  <= '1;
         rx_sr_q  <= '0;
         sck_q    <= 1'b0;
      end else if (load) begin
         active_q <= 1'b1;
         hcnt_q   <= '0;
         tx_sr_q  <= din;
         sck_q    <= 1'b0;
      end else if (active_q && tick) begin
         if (!hcnt_q[0]) begin
            sck_q   <= 1'b1;
            rx_sr_q <= {rx_sr_q[W-2:0], miso_i};
         end else begin
            sck_q   <= 1'b0;
            tx_sr_q <= {tx_sr_q[W-2:0], 1'b1};
         end
         hcnt_q <= hcnt_q + 1'b1;
         if (hcnt_q == LAST) active_q <= 1'b0;
      end
   end

   assign done    = active_q && tick && (hcnt_q == LAST);
   assign sck_o   = sck_q;
   assign mosi_o  = tx_sr_q[W-1];
   assign rx_byte = rx_sr_q;
endmodule

// File: rtl/spi_ring_store.sv
`timescale 1ns/1ps
module spi_ring_store #(
   parameter int DEPTH = 8,
   parameter int W     = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     we,
   input  logic [W-1:0]             wdata,
   input  logic                     adv,
   output logic [W-1:0]             rd_data,
   output logic [$clog2(DEPTH)-1:0] ptr
);
   localparam int PW = $clog2(DEPTH);

   logic [W-1:0]  mem_q [DEPTH];
   logic [PW-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (we) begin
         mem_q[ptr_q] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ptr_q <= '0;
      else if (clr) ptr_q <= '0;
      else if (adv) ptr_q <= ptr_q + 1'b1;
   end

   assign rd_data = mem_q[ptr_q];
   assign ptr     = ptr_q;
endmodule

// File: rtl/spi_cmd_engine.sv
`timescale 1ns/1ps
module spi_cmd_engine
   import spi_cmd_pkg::*;
#(
   parameter int DIV_HALF  = 4,
   parameter int DEPTH     = 8,
   parameter int MAX_BYTES = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_wr,
   input  logic       reg_rd,
   input  logic [3:0] reg_addr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       spi_sck,
   output logic       spi_cs_n,
   output logic       spi_mosi,
   input  logic       spi_miso
);
   localparam int PW = $clog2(DEPTH);
   localparam logic [3:0] CNT_MAX = 4'(MAX_BYTES);

   if (DIV_HALF < 2) begin : g_bad_div
      $error("DIV_HALF must be at least 2");
   end
   if (DEPTH < 2 || DEPTH > 8 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two between 2 and 8");
   end
   if (MAX_BYTES < 1 || MAX_BYTES > 15) begin : g_bad_max
      $error("MAX_BYTES must fit the 4-bit count fields");
   end

   // Saturated count fields: index 0 is transmit (bits 3:0), 1 is receive (bits 7:4)
   logic [3:0] cnt_sat [2];
   for (genvar f = 0; f < 2; f++) begin : g_sat
      assign cnt_sat[f] = (reg_wdata[4*f +: 4] > CNT_MAX) ? CNT_MAX : reg_wdata[4*f +: 4];
   end

   seq_state_t st_q;
   logic       busy_q, cs_n_q, is_op_q;
   logic [7:0] opcode_q;
   logic [3:0] tx_cnt_q, rx_cnt_q;
   logic [4:0] left_q, sent_q;

   logic          tick, sh_done, sh_sck, sh_mosi;
   logic [7:0]    sh_rx, sh_din, ring_rd;
   logic [PW-1:0] ring_ptr;

   // Host access decode: everything is gated off while a command runs
   logic acc_wr, acc_rd, wr_op, wr_cnt, wr_ctrl, host_dwr, host_drd, go, pclr, eng_store;
   assign acc_wr    = reg_wr && !busy_q;
   assign acc_rd    = reg_rd && !busy_q;
   assign wr_op     = acc_wr && (reg_addr == OFS_OPCODE);
   assign wr_cnt    = acc_wr && (reg_addr == OFS_COUNT);
   assign wr_ctrl   = acc_wr && (reg_addr == OFS_CTRL);
   assign host_dwr  = acc_wr && (reg_addr == OFS_DATA);
   assign host_drd  = acc_rd && (reg_addr == OFS_DATA);
   assign go        = wr_ctrl && reg_wdata[CTRL_GO_BIT];
   assign pclr      = wr_ctrl && reg_wdata[CTRL_PCLR_BIT];
   assign eng_store = (st_q == SQ_SHIFT) && sh_done && !is_op_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opcode_q <= '0;
         tx_cnt_q <= '0;
         rx_cnt_q <= '0;
      end else begin
         if (wr_op) opcode_q <= reg_wdata;
         if (wr_cnt) begin
            tx_cnt_q <= cnt_sat[0];
            rx_cnt_q <= cnt_sat[1];
         end
      end
   end

   // Command sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SQ_IDLE;
         busy_q  <= 1'b0;
         cs_n_q  <= 1'b1;
         is_op_q <= 1'b0;
         left_q  <= '0;
         sent_q  <= '0;
      end else begin
         unique case (st_q)
            SQ_IDLE: if (go) begin
               busy_q  <= 1'b1;
               cs_n_q  <= 1'b0;
               is_op_q <= 1'b1;
               left_q  <= 5'(tx_cnt_q) + 5'(rx_cnt_q);
               sent_q  <= '0;
               st_q    <= SQ_LOAD;
            end
            SQ_LOAD: st_q <= SQ_SHIFT;
            SQ_SHIFT: if (sh_done) begin
               is_op_q <= 1'b0;
               if (!is_op_q) sent_q <= sent_q + 1'b1;
               if ((is_op_q && left_q == 5'd0) || (!is_op_q && (sent_q + 5'd1) == left_q))
                  st_q <= SQ_TAIL;
               else
                  st_q <= SQ_LOAD;
            end
            SQ_TAIL: if (tick) begin
               cs_n_q <= 1'b1;
               busy_q <= 1'b0;
               st_q   <= SQ_IDLE;
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign sh_din = is_op_q ? opcode_q :
                   (sent_q < 5'(tx_cnt_q)) ? ring_rd : 8'hFF;

   spi_half_tick #(.DIV_HALF(DIV_HALF)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy_q),
      .tick  (tick)
   );

   spi_byte_shift #(.W(8)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (st_q == SQ_LOAD),
      .din     (sh_din),
      .tick    (tick),
      .miso_i  (spi_miso),
      .sck_o   (sh_sck),
      .mosi_o  (sh_mosi),
      .done    (sh_done),
      .rx_byte (sh_rx)
   );

   spi_ring_store #(.DEPTH(DEPTH), .W(8)) u_ring (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (pclr || go),
      .we      (host_dwr || eng_store),
      .wdata   (busy_q ? sh_rx : reg_wdata),
      .adv     (host_dwr || host_drd || eng_store),
      .rd_data (ring_rd),
      .ptr     (ring_ptr)
   );

   always_comb begin
      unique case (reg_addr)
         OFS_OPCODE: reg_rdata = opcode_q;
         OFS_COUNT:  reg_rdata = {rx_cnt_q, tx_cnt_q};
         OFS_CTRL:   reg_rdata = {7'b0, busy_q};
         OFS_DATA:   reg_rdata = ring_rd;
         OFS_PTR:    reg_rdata = 8'(ring_ptr);
         default:    reg_rdata = 8'h00;
      endcase
   end

   assign spi_sck  = sh_sck;
   assign spi_mosi = sh_mosi;
   assign spi_cs_n = cs_n_q;
endmodule

// File: rtl/spi_cmd_checks.sv
`timescale 1ns/1ps
module spi_cmd_checks #(
   parameter int DEPTH = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     cs_n,
   input logic                     sck,
   input logic                     mosi,
   input logic                     busy,
   input logic [$clog2(DEPTH)-1:0] ptr,
   input logic                     reg_wr,
   input logic                     reg_rd,
   input logic [3:0]               reg_addr,
   input logic                     pclr_bit,
   input logic [7:0]               opcode,
   input logic [3:0]               rx_cnt,
   input logic [3:0]               tx_cnt
);
   localparam int PW = $clog2(DEPTH);

   a_r6_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sck);

   a_r6_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(mosi));

   a_r10_cs_rises_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> cs_n);

   a_r5_cs_falls_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !cs_n);

   a_r11_opcode_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_wr && reg_addr == 4'h0) |=> $stable(opcode));

   a_r2_count_saturated: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_cnt <= 4'd8) && (tx_cnt <= 4'd8));

   a_r3_ptr_step_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && reg_rd && !reg_wr && reg_addr == 4'hC) |=> (ptr == PW'($past(ptr) + 1'b1)));

   a_r4_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && reg_wr && reg_addr == 4'h2 && pclr_bit) |=> (ptr == '0));
endmodule

bind spi_cmd_engine spi_cmd_checks #(.DEPTH(DEPTH)) u_checks (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_n     (spi_cs_n),
   .sck      (spi_sck),
   .mosi     (spi_mosi),
   .busy     (busy_q),
   .ptr      (ring_ptr),
   .reg_wr   (reg_wr),
   .reg_rd   (reg_rd),
   .reg_addr (reg_addr),
   .pclr_bit (reg_wdata[4]),
   .opcode   (opcode_q),
   .rx_cnt   (rx_cnt_q),
   .tx_cnt   (tx_cnt_q)
);

// File: tb/spi_cmd_engine_bench.sv
`timescale 1ns/1ps
module spi_cmd_engine_bench;
   localparam int DIV = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [3:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       spi_sck, spi_cs_n, spi_mosi;
   logic       miso_r = 1'b1;

   always #4 clk = ~clk;

   spi_cmd_engine #(.DIV_HALF(DIV), .DEPTH(8), .MAX_BYTES(8)) u_spi_cmd_engine (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(miso_r)
   );

   int vectors = 0, fails = 0;
   int cmd_id = 0;
   logic [7:0] model [8];
   logic [7:0] mo [17];
   int nb = 0, rises = 0, cyc = 0, last_fall = 0, cs_rise = 0;
   logic prev_sck = 1'b0, prev_cs = 1'b1;

   function automatic logic [7:0] resp(int c, int k);
      return 8'(c * 53 + k * 71 + 9) ^ 8'hA5;
   endfunction

   // Flash-side model, sampled away from the active edge
   always @(negedge clk) begin
      if (prev_cs && !spi_cs_n) begin
         nb = 0; rises = 0;
         miso_r = resp(cmd_id, 0)[7];
      end
      if (!spi_cs_n && spi_sck && !prev_sck) begin
         mo[nb/8] = {mo[nb/8][6:0], spi_mosi};
         nb++; rises++;
         miso_r = resp(cmd_id, nb/8)[7 - (nb % 8)];
      end
      if (prev_sck && !spi_sck) last_fall = cyc;
      if (!prev_cs && spi_cs_n) cs_rise = cyc;
      prev_sck = spi_sck;
      prev_cs  = spi_cs_n;
      cyc++;
   end

   task automatic check(string req, int act, int exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [3:0] a, logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wait_idle();
      logic [7:0] v;
      int guard = 0;
      rd(4'h2, v);
      while (v[0] && guard < 5000) begin
         rd(4'h2, v);
         guard++;
      end
      check("R5 go bit clears", int'(v[0]), 0);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   initial begin
      #(8 * 190000);
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end

   task automatic dump_compare(string req);
      logic [7:0] v;
      wr(4'h2, 8'h10);
      for (int e = 0; e < 8; e++) begin
         rd(4'hC, v);
         check(req, v, model[e]);
      end
   endtask

   initial begin
      logic [7:0] v;
      logic [7:0] op;
      logic [7:0] pl [8];
      for (int i = 0; i < 8; i++) model[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check("R1 cs_n", int'(spi_cs_n), 1);
      check("R1 sck", int'(spi_sck), 0);
      rd(4'h2, v); check("R1 go bit", int'(v), 0);
      rd(4'hD, v); check("R1 pointer", int'(v), 0);

      // R2: saturation of count fields
      wr(4'h1, 8'hF9); rd(4'h1, v); check("R2 both saturate", v, 8'h88);
      wr(4'h1, 8'h3C); rd(4'h1, v); check("R2 tx saturates", v, 8'h38);
      wr(4'h1, 8'h80); rd(4'h1, v); check("R2 in range", v, 8'h80);

      // R3 wrap through the data port, R4 pointer clear
      wr(4'h2, 8'h10);
      for (int k = 0; k < 10; k++) begin
         wr(4'hC, 8'(8'h40 + k));
         model[k % 8] = 8'(8'h40 + k);
      end
      rd(4'hD, v); check("R3 pointer wraps", int'(v), 2);
      wr(4'h2, 8'h10);
      rd(4'hD, v); check("R4 pointer cleared", int'(v), 0);
      rd(4'hC, v); check("R3 read entry 0", v, model[0]);
      rd(4'hD, v); check("R3 read advances", int'(v), 1);
      dump_compare("R3 ring contents");

      // Sweep every transmit/receive count pair
      for (int t = 0; t <= 8; t++) begin
         for (int r = 0; r <= 8; r++) begin
            cmd_id++;
            op = 8'(cmd_id * 29 + 3);
            wr(4'h1, {4'(r), 4'(t)});
            wr(4'h0, op);
            wr(4'h2, 8'h10);
            for (int k = 0; k < t; k++) begin
               pl[k] = 8'(cmd_id * 13 + k * 7 + 1);
               wr(4'hC, pl[k]);
               model[k] = pl[k];
            end
            rd(4'hD, v); check("R3 pointer after payload", int'(v), t % 8);
            wr(4'h2, 8'h01);
            wait_idle();
            rd(4'hD, v); check("R8 pointer after command", int'(v), (t + r) % 8);
            check(t == 0 ? "R9 sck count opcode-only" : "R9 sck count", rises, 8 * (1 + t + r));
            check("R6 opcode first", mo[0], op);
            for (int b = 1; b <= t; b++) check("R7 payload byte", mo[b], pl[b-1]);
            for (int b = t + 1; b <= t + r; b++) check("R7 filler byte", mo[b], 8'hFF);
            check("R10 cs release delay", cs_rise - last_fall, DIV);
            for (int b = 1; b <= t + r; b++) model[(b - 1) % 8] = resp(cmd_id, b);
            dump_compare("R8 ring after command");
            rd(4'h1, v); check("R2 counts hold", v, {4'(r), 4'(t)});
         end
      end

      // R11: accesses during a running command, start with pclr+go together
      cmd_id++;
      op = 8'hC3;
      wr(4'h1, 8'h50);
      wr(4'h0, op);
      wr(4'h2, 8'h11);
      rd(4'h2, v); check("R5 go bit reads 1 while busy", int'(v[0]), 1);
      wr(4'h0, 8'h00);
      wr(4'h1, 8'h11);
      wr(4'hC, 8'h77);
      wr(4'h2, 8'h10);
      rd(4'hC, v);
      wait_idle();
      rd(4'h0, v); check("R11 opcode untouched", v, op);
      rd(4'h1, v); check("R11 counts untouched", v, 8'h50);
      rd(4'hD, v); check("R11 pointer unaffected", int'(v), 5);
      check("R11 opcode sent", mo[0], op);
      for (int b = 1; b <= 5; b++) model[b - 1] = resp(cmd_id, b);
      dump_compare("R11 ring unaffected");

      finish_run();
   end
endmodule